// File: doc/BRIEF.md
# Category Scoring Maximum Detector

This block sits behind a bank of rule rows that are grouped into categories. Each category owns a fixed number of rows, and each row presents one bit that is high when its rule fired for the current pattern. A strobe marks the cycle in which all the row bits belong to one pattern. For every category the block counts how many of its rows fired. It then selects the category with the largest count and reports three things: that category's index, the winning count, and a certainty figure. The certainty is the winning count divided by the row count, given as an unsigned fixed-point fraction.

The block is pipelined with a fixed two-cycle latency. A new pattern may arrive on every clock. Between results the outputs keep the last answer. When no row fires in any category, a dedicated flag is raised and the index and score are both zero. The number of categories, the rows per category and the fraction width are parameters. The latency does not depend on the number of rows.

Top module: `cat_score_max`

## Requirements
- R1: The score of a category is the number of set bits in its slice of `rows_i`; category c occupies bits [c*NUM_ROWS +: NUM_ROWS]. `score_o` reports the score of the selected category.
- R2: `cat_o` is the index of the category with the highest score.
- R3: When several categories share the highest score, the lowest index among them is reported.
- R4: Each cycle with `valid_i` high produces exactly one cycle of `valid_o` high, two clock edges later. Back-to-back patterns give back-to-back results.
- R5: `cert_o` equals floor(score_o * 2^FRAC_W / NUM_ROWS). A full score gives exactly 2^FRAC_W.
- R6: If no row fires in any category, the result has `cat_o` = 0, `score_o` = 0, `cert_o` = 0 and `no_match_o` = 1. Otherwise `no_match_o` = 0.
- R7: While `rst_ni` is low, `valid_o`, `cat_o`, `score_o`, `cert_o` and `no_match_o` are all 0.
- R8: In cycles where `valid_o` is low, `cat_o`, `score_o`, `cert_o` and `no_match_o` keep the values of the last result.
- R9: Changes on `rows_i` while `valid_i` is low have no effect: they raise no `valid_o` and do not change the held outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks a cycle whose row bits form one pattern |
| rows_i | input | NUM_CATS*NUM_ROWS | Row activation bits, one slice per category |
| valid_o | output | 1 | One-cycle pulse that marks a new result |
| cat_o | output | max(1,clog2(NUM_CATS)) | Index of the winning category |
| score_o | output | clog2(NUM_ROWS+1) | Number of rows that fired in the winning category |
| cert_o | output | FRAC_W+1 | Winning score / NUM_ROWS, unsigned, FRAC_W fraction bits |
| no_match_o | output | 1 | High when no row fired in any category |

## Verification
A stale or miscounted stage-one count shows up two edges after the strobe as a wrong `score_o` or `cat_o`. A lost or doubled stage valid shows up in the same cycle as a missing, extra or shifted `valid_o` pulse. A comparison that is not strict moves ties to a higher index. An off-by-one in the scaling shows up in `cert_o` at full and partial scores. Because the reference is compared on every clock, any of these is reported in the first cycle it reaches the ports. Hold and ignore behaviour is observed in the idle cycles between results.

// File: rtl/cat_score_pkg.sv
package cat_score_pkg;
  localparam int unsigned DEF_CATS = 2;
  localparam int unsigned DEF_ROWS = 58;
  localparam int unsigned DEF_FRAC = 8;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/row_popcount.sv
module row_popcount #(
  parameter int unsigned ROWS = 58,
  parameter int unsigned CW   = $clog2(ROWS + 1)
) (
  input  logic [ROWS-1:0] rows_i,
  output logic [CW-1:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < ROWS; i++) cnt_o = cnt_o + CW'(rows_i[i]);
  end
endmodule

// File: rtl/score_argmax.sv
module score_argmax #(
  parameter int unsigned CATS = 2,
  parameter int unsigned CW   = 6,
  parameter int unsigned IW   = 1
) (
  input  logic [CATS*CW-1:0] scores_i,
  output logic [IW-1:0]      idx_o,
  output logic [CW-1:0]      max_o
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    idx_o = '0;
    max_o = scores_i[CW-1:0];
    for (int c = 1; c < CATS; c++) begin
      if (scores_i[c*CW +: CW] > max_o) begin
        max_o = scores_i[c*CW +: CW];
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/cert_scale.sv
module cert_scale #(
  parameter int unsigned ROWS = 58,
  parameter int unsigned CW   = $clog2(ROWS + 1),
  parameter int unsigned FRAC = 8
) (
  input  logic [CW-1:0] score_i,
  output logic [FRAC:0] cert_o
);
  localparam int unsigned PW = CW + FRAC;
  logic [PW-1:0] num;
  logic [PW-1:0] quo;
  assign num    = {score_i, {FRAC{1'b0}}};
  assign quo    = num / PW'(ROWS);
  assign cert_o = quo[FRAC:0];
endmodule

// File: rtl/cat_score_max.sv
module cat_score_max
  import cat_score_pkg::*;
#(
  parameter int unsigned NUM_CATS = DEF_CATS,
  parameter int unsigned NUM_ROWS = DEF_ROWS,
  parameter int unsigned FRAC_W   = DEF_FRAC,
  localparam int unsigned IW      = idx_w(NUM_CATS),
  localparam int unsigned CW      = $clog2(NUM_ROWS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [NUM_CATS*NUM_ROWS-1:0] rows_i,
  output logic                         valid_o,
  output logic [IW-1:0]                cat_o,
  output logic [CW-1:0]                score_o,
  output logic [FRAC_W:0]              cert_o,
  output logic                         no_match_o
);
  logic [NUM_CATS*CW-1:0] cnt_d, cnt_q;
  logic                   v1_q;
  logic [IW-1:0]          best_idx;
  logic [CW-1:0]          best_cnt;
  logic [FRAC_W:0]        best_cert;

  for (genvar c = 0; c < NUM_CATS; c++) begin : g_cat
    row_popcount #(.ROWS(NUM_ROWS), .CW(CW)) u_pop (
      .rows_i (rows_i[c*NUM_ROWS +: NUM_ROWS]),
      .cnt_o  (cnt_d[c*CW +: CW])
    );
  end

  // stage 1: per-category counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) cnt_q <= cnt_d;
    end
  end

  score_argmax #(.CATS(NUM_CATS), .CW(CW), .IW(IW)) u_max (
    .scores_i (cnt_q),
    .idx_o    (best_idx),
    .max_o    (best_cnt)
  );

  cert_scale #(.ROWS(NUM_ROWS), .CW(CW), .FRAC(FRAC_W)) u_cert (
    .score_i (best_cnt),
    .cert_o  (best_cert)
  );

  // stage 2: selected result, held until next pattern
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      cat_o      <= '0;
      score_o    <= '0;
      cert_o     <= '0;
      no_match_o <= 1'b0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) begin
        cat_o      <= best_idx;
        score_o    <= best_cnt;
        cert_o     <= best_cert;
        no_match_o <= (best_cnt == '0);
      end
    end
  end
endmodule

// File: rtl/cat_score_max_chk.sv
module cat_score_max_chk #(
  parameter int unsigned NUM_CATS = 2,
  parameter int unsigned NUM_ROWS = 58,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned IW       = 1,
  parameter int unsigned CW       = 6
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         valid_i,
  input logic [NUM_CATS*NUM_ROWS-1:0] rows_i,
  input logic                         valid_o,
  input logic [IW-1:0]                cat_o,
  input logic [CW-1:0]                score_o,
  input logic [FRAC_W:0]              cert_o,
  input logic                         no_match_o
);
  p_lat_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i, 2) |-> valid_o);
  p_lat_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));
  p_score_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(score_o) <= int'(NUM_ROWS));
  p_cat_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cat_o) < int'(NUM_CATS));
  p_cert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> int'(cert_o) == (int'(score_o) << FRAC_W) / int'(NUM_ROWS));
  p_nomatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && no_match_o |-> score_o == '0 && cat_o == '0);
  p_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !no_match_o |-> score_o != '0);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(cat_o) && $stable(score_o) && $stable(cert_o) && $stable(no_match_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r7: assert (!valid_o && cat_o == '0 && score_o == '0 && cert_o == '0 && !no_match_o);
    end
  end
endmodule

bind cat_score_max cat_score_max_chk #(
  .NUM_CATS (NUM_CATS),
  .NUM_ROWS (NUM_ROWS),
  .FRAC_W   (FRAC_W),
  .IW       (IW),
  .CW       (CW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .rows_i     (rows_i),
  .valid_o    (valid_o),
  .cat_o      (cat_o),
  .score_o    (score_o),
  .cert_o     (cert_o),
  .no_match_o (no_match_o)
);

// File: tb/sim_cat_score_max.sv
`timescale 1ns/1ps
module sim_cat_score_max;
  localparam int K  = 2;
  localparam int M  = 58;
  localparam int F  = 8;
  localparam int IW = 1;
  localparam int CW = 6;
  localparam int WD = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [K*M-1:0] rows_i = '0;
  logic          valid_o;
  logic [IW-1:0] cat_o;
  logic [CW-1:0] score_o;
  logic [F:0]    cert_o;
  logic          no_match_o;

  cat_score_max #(.NUM_CATS(K), .NUM_ROWS(M), .FRAC_W(F)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .rows_i(rows_i),
    .valid_o(valid_o), .cat_o(cat_o), .score_o(score_o), .cert_o(cert_o),
    .no_match_o(no_match_o)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit running = 0, noise = 0;
  int q_due[$], q_cat[$], q_score[$], q_cert[$];
  bit q_nm[$], q_tie[$];
  int l_cat = 0, l_score = 0, l_cert = 0;
  bit l_nm = 0;

  task automatic chk(int act, int exp, string tag, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WD) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD);
      summary();
    end
  end

  // per-cycle comparison against the reference queue
  always @(negedge clk_i) begin
    if (running) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        string ct;
        ct = q_tie[0] ? "R3" : "R2";
        chk(int'(valid_o), 1, "R4", "valid_o");
        chk(int'(cat_o), q_cat[0], ct, "cat_o");
        chk(int'(score_o), q_score[0], "R1", "score_o");
        chk(int'(cert_o), q_cert[0], "R5", "cert_o");
        chk(int'(no_match_o), int'(q_nm[0]), "R6", "no_match_o");
        l_cat = q_cat[0]; l_score = q_score[0]; l_cert = q_cert[0]; l_nm = q_nm[0];
        void'(q_due.pop_front()); void'(q_cat.pop_front()); void'(q_score.pop_front());
        void'(q_cert.pop_front()); void'(q_nm.pop_front()); void'(q_tie.pop_front());
      end else begin
        string ht;
        ht = noise ? "R9" : "R8";
        chk(int'(valid_o), 0, noise ? "R9" : "R4", "valid_o idle");
        chk(int'(cat_o), l_cat, ht, "cat_o hold");
        chk(int'(score_o), l_score, ht, "score_o hold");
        chk(int'(cert_o), l_cert, ht, "cert_o hold");
        chk(int'(no_match_o), int'(l_nm), ht, "no_match_o hold");
      end
    end
  end

  // drive one pattern at a negedge and queue its expected result
  task automatic send(input logic [K*M-1:0] v);
    int best, bi, nbest;
    int cnt[K];
    best = -1; bi = 0; nbest = 0;
    for (int c = 0; c < K; c++) begin
      cnt[c] = 0;
      for (int b = 0; b < M; b++) cnt[c] += int'(v[c*M + b]);
      if (cnt[c] > best) begin best = cnt[c]; bi = c; end
    end
    for (int c = 0; c < K; c++) if (cnt[c] == best) nbest++;
    q_due.push_back(cyc + 2);
    q_cat.push_back(bi);
    q_score.push_back(best);
    q_cert.push_back((best << F) / M);
    q_nm.push_back(best == 0);
    q_tie.push_back(nbest > 1);
    rows_i  = v;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic logic [K*M-1:0] fill(int n0, int n1);
    logic [K*M-1:0] v;
    v = '0;
    for (int b = 0; b < n0; b++) v[b] = 1'b1;
    for (int b = 0; b < n1; b++) v[M + M - 1 - b] = 1'b1;
    return v;
  endfunction

  function automatic logic [K*M-1:0] rnd(int pct);
    logic [K*M-1:0] v;
    for (int b = 0; b < K*M; b++) v[b] = ($urandom_range(99) < pct);
    return v;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    // R7: outputs cleared while reset is held
    rows_i = rnd(50);
    repeat (3) @(negedge clk_i);
    chk(int'(valid_o), 0, "R7", "valid_o in reset");
    chk(int'(cat_o), 0, "R7", "cat_o in reset");
    chk(int'(score_o), 0, "R7", "score_o in reset");
    chk(int'(cert_o), 0, "R7", "cert_o in reset");
    chk(int'(no_match_o), 0, "R7", "no_match_o in reset");
    rows_i = '0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    running = 1;

    send(fill(0, 0));          // R6 nothing fires
    idle(3);
    send(fill(M, 0));          // R5 full score -> 256
    idle(3);
    send(fill(3, 40));         // R2 category 1 wins
    idle(3);
    send(fill(10, 10));        // R3 tie -> 0
    idle(3);
    send(fill(M, M));          // R3 full tie
    send(fill(1, 0));          // R4 back-to-back
    send(fill(0, 1));
    send(fill(29, 17));
    idle(3);

    // R9: row activity without strobe
    noise = 1;
    for (int i = 0; i < 20; i++) begin
      rows_i = rnd(60);
      @(negedge clk_i);
    end
    idle(2);
    noise = 0;

    for (int i = 0; i < 300; i++) begin
      send(rnd(5 + (i % 9) * 11));
      if (i % 4 == 3) idle(i % 3);
    end
    idle(5);
    running = 0;
    if (q_due.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R4 results missing: actual %0d expected 0", q_due.size());
    end
    summary();
  end
endmodule